// File: doc/BRIEF.md
# Looping Register Read Sequencer

This block is the register-access core that sits behind the serial port of a six-channel data converter. It holds eleven 24-bit registers. Six of them are read-only conversion results (addresses 0x00 to 0x05). Five are read/write settings (addresses 0x06 to 0x0A): modulator output, phase, gain, status/communication and configuration. The host opens a read transaction at an address of its choice, then takes the word one byte per strobe, most significant byte first. After the third byte of each word, an internal address counter moves to the next address. The read-mode field decides the wrap: the counter holds still, loops inside a small group, loops inside the register type, or loops over the whole map.

Channel results are streamed from a shadow copy rather than from the live converter outputs. The copy is taken when the read opens. If a data-ready event arrives while a read is open, it is remembered, and the copy is refreshed at the next word boundary. A word that is partly shifted out is therefore never mixed from two conversions. A shifter that turns bytes into serial bits sits outside this block, and so does the converter itself.

The control is a two-state machine. `ST_IDLE` moves to `ST_STREAM` on the *open* transition (`rd_start` high). `ST_STREAM` moves back to `ST_IDLE` on the *close* transition (`rd_end` high). Every other cycle, each state stays where it is.

Top module: `loop_rd_seq`

## Requirements
- R1: After reset, `byte_valid` is low, all five setting registers read as zero, and the read mode is 00.
- R2: In `ST_STREAM`, `byte_valid` is high. The word at the current address comes out in three strobes of `byte_take`: bits 23:16 first, then 15:8, then 7:0.
- R3: With read mode 00, the address does not change, and the same register is returned word after word.
- R4: With read mode 01, the address loops inside its group after each word: {0x00,0x01}, {0x02,0x03}, {0x04,0x05}, {0x06,0x07,0x08} and {0x09,0x0A}.
- R5: With read mode 10, the address loops over 0x00–0x05 for channel data and over 0x06–0x0A for settings.
- R6: With read mode 11, the address steps through 0x00–0x0A and wraps from 0x0A to 0x00.
- R7: When a read opens, all channel values are copied. Later changes on `ch_data` without a `dr_pulse` do not reach the bytes read.
- R8: A `dr_pulse` during a read is held until a word boundary, and the copy is then refreshed from `ch_data`. The bytes left in the current word still come from the old copy, and the next word carries the new value.
- R9: Writes to 0x06–0x0A are stored and read back. Writes to 0x00–0x05 are ignored.
- R10: The read mode is bits 23:22 of the status/communication register (0x09). It is sampled when a read opens, and a write to that register mid-read does not change the looping of the open read.
- R11: `rd_end` closes the read, and `byte_valid` is low in the next cycle. A new read restarts at byte 0 of the new start address.
- R12: Addresses 0x0B–0x0F read as zero. In any looping mode, the counter goes from such an address to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dr_pulse | input | 1 | One-cycle data-ready event from the converter |
| ch_data | input | 144 | Live channel results, channel k in bits 24k+23:24k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 24 | Write data |
| rd_start | input | 1 | Opens a read at `rd_addr` (ignored while open) |
| rd_addr | input | 4 | Start address of the read |
| rd_end | input | 1 | Closes the read |
| byte_take | input | 1 | Host takes the byte on `byte_out` this cycle |
| byte_out | output | 8 | Current byte of the current word |
| byte_valid | output | 1 | High while a read is open |

## Verification
The hardest case to reach is a data-ready event that lands while a word is partly shifted out. The bench takes one byte, changes `ch_data`, pulses `dr_pulse` in a gap between strobes, and then takes the last two bytes (expected: the old word) and the next word (expected: the new word). It also pulses data-ready before the first byte of a word, where the refresh must take effect at once. A second case writes the mode bits in the middle of an open read, to show that the looping stays as it was when the read opened.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    localparam int WORD_W         = 24;
    localparam int BYTE_W         = 8;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int IDX_W          = $clog2(BYTES_PER_WORD);
    localparam int NUM_CH         = 6;
    localparam int NUM_CFG        = 5;
    localparam int NUM_REG        = NUM_CH + NUM_CFG;
    localparam int ADDR_W         = 4;
    localparam int STATUS_IDX     = 3;
    localparam int MODE_MSB       = 23;

    localparam logic [ADDR_W-1:0] A_CFG_BASE = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] A_MID_HI   = ADDR_W'(NUM_CH + 2);
    localparam logic [ADDR_W-1:0] A_LAST     = ADDR_W'(NUM_REG - 1);

    typedef enum logic [1:0] {
        RM_SINGLE = 2'b00,
        RM_GROUP  = 2'b01,
        RM_TYPE   = 2'b10,
        RM_ALL    = 2'b11
    } rmode_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } seq_state_t;
endpackage

// File: rtl/lrs_addr_step.sv
module lrs_addr_step
    import lrs_pkg::*;
(
    input  logic [ADDR_W-1:0] cur,
    input  rmode_t            mode,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] lo, hi;

    always_comb begin
        lo = cur;
        hi = cur;
        unique case (mode)
            RM_SINGLE: begin
                lo = cur;
                hi = cur;
            end
            RM_GROUP: begin
                if (cur < A_CFG_BASE) begin
                    lo = {cur[ADDR_W-1:1], 1'b0};
                    hi = {cur[ADDR_W-1:1], 1'b1};
                end else if (cur <= A_MID_HI) begin
                    lo = A_CFG_BASE;
                    hi = A_MID_HI;
                end else begin
                    lo = A_MID_HI + ADDR_W'(1);
                    hi = A_LAST;
                end
            end
            RM_TYPE: begin
                if (cur < A_CFG_BASE) begin
                    lo = '0;
                    hi = A_CFG_BASE - ADDR_W'(1);
                end else begin
                    lo = A_CFG_BASE;
                    hi = A_LAST;
                end
            end
            RM_ALL: begin
                lo = '0;
                hi = A_LAST;
            end
        endcase

        if (cur > A_LAST)
            nxt = (mode == RM_SINGLE) ? cur : '0;
        else if (cur == hi)
            nxt = lo;
        else
            nxt = cur + ADDR_W'(1);
    end
endmodule

// File: rtl/lrs_snapshot.sv
module lrs_snapshot
    import lrs_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int W    = WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            active,
    input  logic            boundary,
    input  logic            dr,
    input  logic [N_CH*W-1:0] live,
    output logic [N_CH*W-1:0] shadow
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            pend_q <= 1'b0;
        end else if (capture) begin
            shadow <= live;
            pend_q <= 1'b0;
        end else if (active) begin
            if (boundary && (pend_q || dr)) begin
                shadow <= live;
                pend_q <= 1'b0;
            end else if (dr) begin
                pend_q <= 1'b1;
            end
        end else begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/lrs_cfg_regs.sv
module lrs_cfg_regs
    import lrs_pkg::*;
#(
    parameter int N_CFG = NUM_CFG,
    parameter int BASE  = NUM_CH,
    parameter int W     = WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [W-1:0]       wr_data,
    output logic [N_CFG*W-1:0] cfg
);
    for (genvar g = 0; g < N_CFG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg[g*W +: W] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(BASE + g)))
                cfg[g*W +: W] <= wr_data;
        end
    end
endmodule

// File: rtl/loop_rd_seq.sv
module loop_rd_seq
    import lrs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dr_pulse,
    input  logic [NUM_CH*WORD_W-1:0] ch_data,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     rd_start,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     rd_end,
    input  logic                     byte_take,
    output logic [BYTE_W-1:0]        byte_out,
    output logic                     byte_valid
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES_PER_WORD - 1);

    seq_state_t state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_nxt;
    logic [IDX_W-1:0]  idx_q;
    rmode_t            mode_q, cfg_mode;

    logic [NUM_CH*WORD_W-1:0]  shadow_flat;
    logic [NUM_CFG*WORD_W-1:0] cfg_flat;
    logic [WORD_W-1:0]         word_sel;

    logic start_evt, take_eff, word_end, boundary, snap_active;

    assign cfg_mode    = rmode_t'(cfg_flat[STATUS_IDX*WORD_W + MODE_MSB -: 2]);
    assign start_evt   = (state_q == ST_IDLE) && rd_start;
    assign take_eff    = (state_q == ST_STREAM) && byte_take && !rd_end;
    assign word_end    = take_eff && (idx_q == LAST_IDX);
    assign boundary    = ((idx_q == '0) && !take_eff) || word_end;
    assign snap_active = (state_q == ST_STREAM) && !rd_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (rd_start) state_d = ST_STREAM;
            ST_STREAM: if (rd_end)   state_d = ST_IDLE;
        endcase
    end

    // address counter, byte index, latched mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            idx_q  <= '0;
            mode_q <= RM_SINGLE;
        end else if (start_evt) begin
            addr_q <= rd_addr;
            idx_q  <= '0;
            mode_q <= cfg_mode;
        end else if (take_eff) begin
            if (idx_q == LAST_IDX) begin
                idx_q  <= '0;
                addr_q <= addr_nxt;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    lrs_addr_step u_step (
        .cur  (addr_q),
        .mode (mode_q),
        .nxt  (addr_nxt)
    );

    lrs_snapshot #(.N_CH(NUM_CH), .W(WORD_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (start_evt),
        .active   (snap_active),
        .boundary (boundary),
        .dr       (dr_pulse),
        .live     (ch_data),
        .shadow   (shadow_flat)
    );

    lrs_cfg_regs #(.N_CFG(NUM_CFG), .BASE(NUM_CH), .W(WORD_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg_flat)
    );

    always_comb begin
        word_sel = '0;
        if (addr_q < A_CFG_BASE)
            word_sel = shadow_flat[int'(addr_q)*WORD_W +: WORD_W];
        else if (addr_q <= A_LAST)
            word_sel = cfg_flat[(int'(addr_q) - NUM_CH)*WORD_W +: WORD_W];
    end

    // outputs
    always_comb begin
        byte_valid = (state_q == ST_STREAM);
        byte_out   = byte_valid ? word_sel[WORD_W-1 - int'(idx_q)*BYTE_W -: BYTE_W] : '0;
    end
endmodule

// File: rtl/lrs_seq_chk.sv
module lrs_seq_chk
    import lrs_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rd_start,
    input logic                     rd_end,
    input logic                     byte_take,
    input logic                     byte_valid,
    input logic [ADDR_W-1:0]        addr_q,
    input logic [IDX_W-1:0]         idx_q,
    input logic [1:0]               mode_q,
    input logic [NUM_CH*WORD_W-1:0] shadow
);
    // R11
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && rd_end) |=> !byte_valid);

    // R2
    open_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && rd_start) |=> byte_valid);

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(BYTES_PER_WORD - 1));

    // R8
    no_tear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && idx_q != '0) |-> $stable(shadow));

    // R3
    single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && mode_q == 2'b00) |=> $stable(addr_q));

    // R6
    full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && mode_q == 2'b11 && addr_q == A_LAST && idx_q == IDX_W'(BYTES_PER_WORD - 1)
         && byte_take && !rd_end) |=> (addr_q == '0));
endmodule

bind loop_rd_seq lrs_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_start   (rd_start),
    .rd_end     (rd_end),
    .byte_take  (byte_take),
    .byte_valid (byte_valid),
    .addr_q     (addr_q),
    .idx_q      (idx_q),
    .mode_q     (mode_q),
    .shadow     (shadow_flat)
);

// File: tb/loop_rd_seq_tb.sv
module loop_rd_seq_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dr_pulse = 1'b0;
    logic [143:0] ch_data;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_addr = '0;
    logic [23:0]  wr_data = '0;
    logic         rd_start = 1'b0;
    logic [3:0]   rd_addr = '0;
    logic         rd_end = 1'b0;
    logic         byte_take = 1'b0;
    logic [7:0]   byte_out;
    logic         byte_valid;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [23:0] live  [6];
    logic [23:0] snap  [6];
    logic [23:0] cfg_m [5];
    logic [3:0]  addr_m;
    int          idx_m;
    logic [1:0]  mode_m;
    bit          pend_m;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    always_comb
        for (int k = 0; k < 6; k++) ch_data[k*24 +: 24] = live[k];

    loop_rd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .dr_pulse(dr_pulse), .ch_data(ch_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_start(rd_start), .rd_addr(rd_addr), .rd_end(rd_end),
        .byte_take(byte_take), .byte_out(byte_out), .byte_valid(byte_valid)
    );

    function automatic logic [23:0] exp_word(logic [3:0] a);
        if (a < 6)        return snap[a];
        else if (a <= 10) return cfg_m[a - 6];
        else              return 24'h0;
    endfunction

    function automatic logic [3:0] tb_next(logic [3:0] a, logic [1:0] m);
        int first, last;
        if (m == 2'b00) return a;
        if (a > 10) return 4'd0;
        case (m)
            2'b01: begin
                if (a <= 5)      begin first = (a / 2) * 2; last = first + 1; end
                else if (a <= 8) begin first = 6; last = 8; end
                else             begin first = 9; last = 10; end
            end
            2'b10: begin
                first = (a <= 5) ? 0 : 6;
                last  = (a <= 5) ? 5 : 10;
            end
            default: begin first = 0; last = 10; end
        endcase
        return (int'(a) == last) ? 4'(first) : a + 4'd1;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: compares each taken byte with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (byte_take) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected byte", {24'h0, byte_out}, 32'h0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(byte_valid && byte_out == e, t, {23'h0, byte_valid, byte_out}, {24'h1, e});
                end
            end
        end
    end

    // all tasks start and end at a falling edge
    task automatic write_reg(logic [3:0] a, logic [23:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a >= 6 && a <= 10) cfg_m[a - 6] = d;
    endtask

    task automatic set_mode(logic [1:0] m);
        write_reg(4'd9, {m, 22'h0});
    endtask

    task automatic start_read(logic [3:0] a);
        rd_start = 1'b1; rd_addr = a;
        for (int k = 0; k < 6; k++) snap[k] = live[k];
        addr_m = a; idx_m = 0; mode_m = cfg_m[3][23:22]; pend_m = 1'b0;
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    task automatic take_byte(string tag);
        logic [23:0] w;
        if (idx_m == 0 && pend_m) begin
            for (int k = 0; k < 6; k++) snap[k] = live[k];
            pend_m = 1'b0;
        end
        w = exp_word(addr_m);
        exp_q.push_back(w[23 - idx_m*8 -: 8]);
        tag_q.push_back(tag);
        byte_take = 1'b1;
        @(negedge clk);
        byte_take = 1'b0;
        if (idx_m == 2) begin
            idx_m = 0;
            addr_m = tb_next(addr_m, mode_m);
            if (pend_m) begin
                for (int k = 0; k < 6; k++) snap[k] = live[k];
                pend_m = 1'b0;
            end
        end else begin
            idx_m++;
        end
    endtask

    task automatic take_words(int n, string tag);
        for (int i = 0; i < n * 3; i++) take_byte(tag);
    endtask

    task automatic expect_addr(logic [3:0] a, string tag);
        check(addr_m == a, tag, {28'h0, addr_m}, {28'h0, a});
    endtask

    task automatic data_ready(int ch, logic [23:0] v);
        live[ch] = v;
        dr_pulse = 1'b1;
        @(negedge clk);
        dr_pulse = 1'b0;
        pend_m = 1'b1;
    endtask

    task automatic end_read(string tag);
        rd_end = 1'b1;
        @(negedge clk);
        rd_end = 1'b0;
        check(byte_valid == 1'b0, tag, {31'h0, byte_valid}, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 6; k++) live[k] = 24'h100000 * (k + 1) + 24'h0A0B0C + 24'(k);
        for (int k = 0; k < 5; k++) cfg_m[k] = 24'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle after reset, settings zero, mode 00
        check(byte_valid == 1'b0, "R1 reset valid", {31'h0, byte_valid}, 32'h0);
        start_read(4'd9);
        check(byte_valid == 1'b1, "R2 valid on open", {31'h0, byte_valid}, 32'h1);
        take_words(2, "R1 status zero, mode 00 repeats");
        end_read("R11 close");
        start_read(4'd6);
        take_words(1, "R1 modulator zero");
        end_read("R11 close");

        // R9: settings stored, channel writes ignored
        write_reg(4'd2, 24'hDEAD01);
        write_reg(4'd6, 24'h123456);
        write_reg(4'd7, 24'hA5C3E1);
        write_reg(4'd8, 24'h0FF0F0);
        write_reg(4'd10, 24'h7E8D9C);
        start_read(4'd2);
        take_words(1, "R9 channel write ignored");
        end_read("R11 close");
        start_read(4'd7);
        take_words(1, "R9 setting readback");
        end_read("R11 close");

        // R3: mode 00 repeats the same channel, byte order R2
        start_read(4'd1);
        take_words(3, "R3 R2 repeat channel 1");
        expect_addr(4'd1, "R3 address held");
        end_read("R11 close");

        // R4: group loops
        set_mode(2'b01);
        start_read(4'd1);
        take_words(3, "R4 group 0-1");
        end_read("R11 close");
        start_read(4'd7);
        take_words(4, "R4 group 6-8");
        end_read("R11 close");
        start_read(4'd10);
        take_words(3, "R4 group 9-10");
        end_read("R11 close");
        start_read(4'd5);
        take_words(2, "R4 group 4-5");
        end_read("R11 close");

        // R5: type loops
        set_mode(2'b10);
        start_read(4'd4);
        take_words(3, "R5 channel type wrap");
        expect_addr(4'd1, "R5 next address");
        end_read("R11 close");
        start_read(4'd9);
        take_words(3, "R5 setting type wrap");
        end_read("R11 close");

        // R6: whole map
        set_mode(2'b11);
        start_read(4'd9);
        take_words(4, "R6 full map wrap");
        end_read("R11 close");

        // R12: unmapped address reads zero, then 0x00
        start_read(4'd12);
        take_words(2, "R12 unmapped");
        end_read("R11 close");

        // R10: mode written mid-read does not change looping
        start_read(4'd0);
        take_words(1, "R10 before write");
        set_mode(2'b00);
        take_words(2, "R10 mode kept at 11");
        expect_addr(4'd3, "R10 address kept advancing");
        end_read("R11 close");

        // R7: live change without data-ready is invisible
        start_read(4'd3);
        take_byte("R7 first byte");
        live[3] = 24'h55AA33;
        @(negedge clk);
        take_byte("R7 no refresh");
        take_byte("R7 no refresh");
        take_words(1, "R7 still old copy");
        end_read("R11 close");

        // R8: data-ready mid-word, applied at the boundary
        start_read(4'd3);
        take_byte("R8 first byte");
        data_ready(3, 24'h9C8B7A);
        take_byte("R8 old word kept");
        take_byte("R8 old word kept");
        take_words(1, "R8 new word");
        // data-ready before the first byte of a word
        data_ready(3, 24'h314159);
        take_words(1, "R8 refresh at boundary");
        end_read("R11 close");

        // R11: reopen restarts at byte 0 of the new address
        start_read(4'd0);
        take_byte("R11 partial");
        end_read("R11 close mid-word");
        start_read(4'd5);
        take_words(1, "R11 fresh start");
        end_read("R11 close");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule